// File: doc/BRIEF.md
# Three-Copy Majority Combiner

This receiver block gathers three received copies of the same packet, presented one per cycle as parallel words, and merges them with a bitwise 2-of-3 vote. The voted word carries its own integrity code in its low byte. When the voted word passes the check, it is delivered at once. When it fails, the block searches for a correction. It treats as suspect every bit position where the three copies are not unanimous, and it tries inverting subsets of those positions, one candidate per clock. The first candidate that passes is delivered.

If no candidate passes, or if there are too many suspect positions to search, the block raises a single-cycle request for a fresh set of three copies. After a delivery or a request it is ready to collect a new set. Copies presented while a search is running are discarded.

Top module: `tmc_combiner`

## Requirements
- R1: After reset, `out_vld` and `resend_req` are low and no copy is held, so three new copies are needed before any outcome appears.
- R2: Copies are accepted on cycles where `copy_vld` is high while the block is collecting. The third accepted copy starts an evaluation. Each bit of the voted word equals the value held by at least two of the three copies.
- R3: A word is intact when its low 8 bits equal the CRC-8 of its upper `PKT_W-8` bits. The CRC uses generator x^8+x^2+x+1 (0x07) and an all-zero start value. Bits are processed most significant first, with no reflection and no final inversion.
- R4: If the voted word is intact, it appears on `out_data` with `out_vld` high two cycles after the cycle in which the third copy was presented.
- R5: Suspect positions are the bits where the three copies are not all equal. Candidate k inverts the j-th lowest suspect position exactly when bit j of k is 1. Candidates are tried in ascending k starting at 0, one per cycle. The first intact candidate is delivered 2+k cycles after the third copy was presented, and it differs from the voted word only at suspect positions.
- R6: If more than 4 positions are suspect, no candidate is tried. `resend_req` pulses two cycles after the third copy was presented, even if the voted word happens to be intact.
- R7: If all 2^n candidates fail (n suspect positions, n ≤ 4), `resend_req` pulses 1+2^n cycles after the third copy was presented.
- R8: Copies presented during a search are ignored. After each delivery or resend request, the copy count restarts from zero.
- R9: `out_vld` and `resend_req` are single-cycle pulses that are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| copy_vld | input | 1 | A received copy is present on `copy_data` |
| copy_data | input | PKT_W | Received copy: payload in upper bits, CRC-8 in low 8 bits |
| out_vld | output | 1 | One-cycle strobe: `out_data` holds an intact packet |
| out_data | output | PKT_W | Delivered (possibly corrected) packet |
| resend_req | output | 1 | One-cycle request for three fresh copies |

## Verification
The search's final decision and a newly arriving copy can fall in the same cycle. In that last search cycle the block is still searching, so the copy must be dropped and must not count toward the next set. The bench provokes this by driving `copy_vld` on every cycle of a multi-cycle search, up to and including the deciding cycle. It then presents only two genuine copies, pauses, and requires that nothing comes out until the third copy arrives. Latency and data are judged against a reference search written independently from the requirements, which uses polynomial division for the integrity check.

// File: rtl/tmc_pkg.sv
package tmc_pkg;

    typedef enum logic [0:0] {
        ST_COLLECT = 1'b0,
        ST_SEARCH  = 1'b1
    } tmc_state_e;

endpackage

// File: rtl/tmc_vote.sv
module tmc_vote #(
    parameter int PKT_W = 16,
    localparam int PC_W = $clog2(PKT_W + 1)
) (
    input  logic [PKT_W-1:0] cp_a,
    input  logic [PKT_W-1:0] cp_b,
    input  logic [PKT_W-1:0] cp_c,
    output logic [PKT_W-1:0] vote,
    output logic [PKT_W-1:0] mask,
    output logic [PC_W-1:0]  pop
);
    always_comb begin
        vote = (cp_a & cp_b) | (cp_b & cp_c) | (cp_a & cp_c);
        mask = (cp_a ^ cp_b) | (cp_b ^ cp_c);
        pop  = PC_W'($countones(mask));
    end
endmodule

// File: rtl/tmc_flip_map.sv
module tmc_flip_map #(
    parameter int PKT_W    = 16,
    parameter int MAX_FLIP = 4
) (
    input  logic [PKT_W-1:0]    mask,
    input  logic [MAX_FLIP-1:0] combo,
    output logic [PKT_W-1:0]    flip
);
    logic [MAX_FLIP-1:0] rem;

    always_comb begin
        flip = '0;
        rem  = combo;
        for (int i = 0; i < PKT_W; i++) begin
            if (mask[i]) begin
                flip[i] = rem[0];
                rem     = rem >> 1;
            end
        end
    end
endmodule

// File: rtl/tmc_crc_chk.sv
module tmc_crc_chk #(
    parameter int              PKT_W = 16,
    parameter int              CRC_W = 8,
    parameter logic [CRC_W-1:0] POLY = 8'h07
) (
    input  logic [PKT_W-1:0] word,
    output logic             ok
);
    localparam int MSG_W = PKT_W - CRC_W;

    logic [CRC_W-1:0] acc;
    logic             fb;

    always_comb begin
        acc = '0;
        for (int i = MSG_W - 1; i >= 0; i--) begin
            fb  = acc[CRC_W-1] ^ word[CRC_W+i];
            acc = acc << 1;
            if (fb) acc = acc ^ POLY;
        end
        ok = (acc == word[CRC_W-1:0]);
    end
endmodule

// File: rtl/tmc_combiner.sv
module tmc_combiner #(
    parameter int              PKT_W    = 16,
    parameter int              CRC_W    = 8,
    parameter logic [CRC_W-1:0] POLY    = 8'h07,
    parameter int              MAX_FLIP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             copy_vld,
    input  logic [PKT_W-1:0] copy_data,
    output logic             out_vld,
    output logic [PKT_W-1:0] out_data,
    output logic             resend_req
);
    import tmc_pkg::*;

    localparam int PC_W  = $clog2(PKT_W + 1);
    localparam int CMB_W = MAX_FLIP;

    typedef struct packed {
        tmc_state_e       st;
        logic [1:0]       cnt;
        logic [PKT_W-1:0] cp0;
        logic [PKT_W-1:0] cp1;
        logic [PKT_W-1:0] cp2;
        logic [CMB_W-1:0] combo;
        logic             ovld;
        logic [PKT_W-1:0] odata;
        logic             rsnd;
    } regs_t;

    regs_t q, d;

    logic [PKT_W-1:0] vote, mask, flip, cand;
    logic [PC_W-1:0]  pop;
    logic             cand_ok;
    logic [CMB_W:0]   last_combo;
    logic             too_wide;

    tmc_vote #(.PKT_W(PKT_W)) vote_i (
        .cp_a (q.cp0),
        .cp_b (q.cp1),
        .cp_c (q.cp2),
        .vote (vote),
        .mask (mask),
        .pop  (pop)
    );

    tmc_flip_map #(.PKT_W(PKT_W), .MAX_FLIP(MAX_FLIP)) flip_i (
        .mask  (mask),
        .combo (q.combo),
        .flip  (flip)
    );

    assign cand = vote ^ flip;

    tmc_crc_chk #(.PKT_W(PKT_W), .CRC_W(CRC_W), .POLY(POLY)) crc_i (
        .word (cand),
        .ok   (cand_ok)
    );

    always_comb begin
        too_wide   = (pop > PC_W'(MAX_FLIP));
        last_combo = '0;
        for (int i = 0; i < CMB_W; i++) begin
            if (PC_W'(i) < pop) last_combo[i] = 1'b1;
        end

        d      = q;
        d.ovld = 1'b0;
        d.rsnd = 1'b0;
        case (q.st)
            ST_COLLECT: begin
                if (copy_vld) begin
                    case (q.cnt)
                        2'd0:    d.cp0 = copy_data;
                        2'd1:    d.cp1 = copy_data;
                        default: d.cp2 = copy_data;
                    endcase
                    if (q.cnt == 2'd2) begin
                        d.st    = ST_SEARCH;
                        d.cnt   = 2'd0;
                        d.combo = '0;
                    end else begin
                        d.cnt = q.cnt + 2'd1;
                    end
                end
            end
            default: begin
                if (too_wide) begin
                    d.rsnd = 1'b1;
                    d.st   = ST_COLLECT;
                end else if (cand_ok) begin
                    d.ovld  = 1'b1;
                    d.odata = cand;
                    d.st    = ST_COLLECT;
                end else if ({1'b0, q.combo} == last_combo) begin
                    d.rsnd = 1'b1;
                    d.st   = ST_COLLECT;
                end else begin
                    d.combo = q.combo + CMB_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_vld    = q.ovld;
    assign out_data   = q.odata;
    assign resend_req = q.rsnd;

    AST_SINGLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_vld && resend_req)); // R9

    AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |=> !out_vld); // R9

    AST_FROZEN_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SEARCH) |=> ($stable(q.cp0) && $stable(q.cp1) && $stable(q.cp2))); // R8

    AST_FLIP_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (((out_data ^ vote) & ~mask) == '0)); // R5

    AST_WIDE_RESEND: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_SEARCH) && (pop > PC_W'(MAX_FLIP))) |=> resend_req); // R6

    AST_DELIVER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (pop <= PC_W'(MAX_FLIP))); // R6

endmodule

// File: tb/tmc_combiner_tb_top.sv
module tmc_combiner_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         copy_vld = 1'b0;
    logic [W-1:0] copy_data = '0;
    logic         out_vld;
    logic [W-1:0] out_data;
    logic         resend_req;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #5 clk = ~clk;

    tmc_combiner dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .copy_vld   (copy_vld),
        .copy_data  (copy_data),
        .out_vld    (out_vld),
        .out_data   (out_data),
        .resend_req (resend_req)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // remainder of the whole word divided by x^8+x^2+x+1
    function automatic logic [7:0] div_rem(input logic [W-1:0] w);
        logic [W-1:0] r = w;
        for (int i = W - 1; i >= 8; i--)
            if (r[i]) r = r ^ (W'(16'h0107) << (i - 8));
        return r[7:0];
    endfunction

    function automatic logic [W-1:0] mk_pkt(input logic [W-9:0] msg);
        return {msg, div_rem({msg, 8'h00})};
    endfunction

    // reference search built from R2, R3, R5, R6, R7
    task automatic model(input logic [W-1:0] a, b, c,
                         output int lat, output bit good, output logic [W-1:0] res);
        logic [W-1:0] v, cand;
        int pos[W];
        int n = 0;
        for (int i = 0; i < W; i++) begin
            v[i] = (a[i] + b[i] + c[i]) >= 2;
            if (!(a[i] == b[i] && b[i] == c[i])) begin
                pos[n] = i;
                n++;
            end
        end
        good = 1'b0;
        res  = '0;
        if (n > 4) begin
            lat = 2;
            return;
        end
        for (int k = 0; k < (1 << n); k++) begin
            cand = v;
            for (int j = 0; j < n; j++)
                if (((k >> j) & 1) != 0) cand[pos[j]] = ~cand[pos[j]];
            if (div_rem(cand) == 8'h00) begin
                lat = 2 + k;
                good = 1'b1;
                res = cand;
                return;
            end
        end
        lat = 1 + (1 << n);
    endtask

    // present three copies, optional idle gap before the third, optional
    // junk copies during the search; then judge the outcome
    task automatic run_case(input logic [W-1:0] a, b, c, input int gap,
                            input bit inject, input string req, input int want_lat);
        int  lat;
        bit  good;
        logic [W-1:0] res;
        int  seen = 0;
        model(a, b, c, lat, good, res);
        if (want_lat >= 0)
            chk(lat == want_lat, req, "reference latency", lat, want_lat);
        @(negedge clk); copy_vld = 1'b1; copy_data = a;
        @(negedge clk); copy_data = b;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk); copy_vld = 1'b0;
            chk(!out_vld && !resend_req, "R8", "no outcome before third copy",
                {out_vld, resend_req}, 0);
        end
        @(negedge clk); copy_vld = 1'b1; copy_data = c;
        for (int cyc = 1; cyc <= 40; cyc++) begin
            @(negedge clk);
            if (out_vld || resend_req) begin
                seen = cyc;
                break;
            end
            copy_vld  = inject;
            copy_data = W'(16'hBEEF) ^ W'(cyc);
        end
        copy_vld = 1'b0;
        chk(seen == lat, req, "outcome latency", seen, lat);
        chk(out_vld == good && resend_req == !good, req, "outcome kind",
            {out_vld, resend_req}, {good, !good});
        if (good) chk(out_data == res, req, "delivered data", out_data, res);
        @(negedge clk);
        chk(!out_vld && !resend_req, "R9", "strobe width one cycle",
            {out_vld, resend_req}, 0);
    endtask

    task automatic t_reset();
        logic [W-1:0] g = mk_pkt(8'h3C);
        chk(!out_vld && !resend_req, "R1", "outputs after reset", {out_vld, resend_req}, 0);
        run_case(g ^ 16'h0100, g, g, 4, 1'b0, "R1", 2);
    endtask

    task automatic t_clean();
        logic [W-1:0] g1 = mk_pkt(8'hA5);
        logic [W-1:0] g2 = mk_pkt(8'h00);
        logic [W-1:0] g3 = mk_pkt(8'hFF);
        run_case(g1, g1, g1, 0, 1'b0, "R4", 2);
        run_case(g2 ^ 16'h8000, g2 ^ 16'h0001, g2, 0, 1'b0, "R2", 2);
        run_case(g3, g3 ^ 16'h0420, g3 ^ 16'h1002, 0, 1'b0, "R3", 2);
    endtask

    task automatic t_flip();
        logic [W-1:0] g = mk_pkt(8'hA5);
        run_case(g ^ 16'h0200, g ^ 16'h0200, g, 0, 1'b0, "R5", 3);
        run_case(g ^ 16'h1000, g ^ 16'h1000, g ^ 16'h0004, 0, 1'b0, "R5", 4);
        run_case(g ^ 16'h8421, g ^ 16'h8421, g, 0, 1'b0, "R5", -1);
    endtask

    task automatic t_wide();
        logic [W-1:0] g = mk_pkt(8'h5A);
        run_case(g ^ 16'h001F, g, g, 0, 1'b0, "R6", 2);
    endtask

    task automatic t_exhaust();
        logic [W-1:0] g = mk_pkt(8'h71);
        run_case(g ^ 16'h0082, g ^ 16'h4080, g ^ 16'h0080, 0, 1'b0, "R7", 5);
    endtask

    task automatic t_ignore();
        logic [W-1:0] g  = mk_pkt(8'h96);
        logic [W-1:0] g2 = mk_pkt(8'h2D);
        run_case(g ^ 16'h0009, g ^ 16'h0048, g ^ 16'h0808, 0, 1'b1, "R8", -1);
        run_case(g2, g2 ^ 16'h0010, g2, 5, 1'b0, "R8", 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_clean();
        t_flip();
        t_wide();
        t_exhaust();
        t_ignore();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule